// File: doc/BRIEF.md
# Serial-Programmed Feedback Divider Control Port

This block is the control side of a frequency-margining clock synthesizer. A three-wire serial port made of a serial clock, a data line and a load strobe writes a 6-bit feedback divide word. While the load strobe is high, the port shifts the word in, most significant bit first. When the strobe falls, the word is captured into a holding register. A mode input then chooses what drives the divider: either a fixed nominal divide of 50, or the captured margining word. Each step of one away from 50 moves the synthesized frequency by 2 % of nominal.

The port runs entirely in a fast system clock domain. All four control inputs pass through two-flop synchronizers, and serial clock and strobe edges are found by comparing successive synchronized samples. The serial clock may therefore run at up to a quarter of the system clock rate. The block also raises a flag when the active divide value lies in the lockable window of 45 to 55. A word outside that window is still captured and presented, but with the flag low.

Top module: `mdiv_serial_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, `div_o` is 50 and `div_ok_o` is 1, and the held margining word is 50.
- R2: While the load strobe is high, each rising edge of the serial clock shifts the data bit into the bottom of a 6-bit shift register, so the first bit sent ends up as bit 5 (MSB first). If more than six edges occur, the last six bits sent are kept.
- R3: A high-to-low transition of the load strobe copies the shift register into the held word. The held word, and the output derived from it, do not change while the strobe is still high.
- R4: While the load strobe is low, serial clock and data activity leave the shift register untouched: a later strobe pulse with no clock edges re-captures the previously shifted word.
- R5: With the mode input low, `div_o` is 50 whatever word is held. Words can still be loaded in this mode and take effect when the mode goes high.
- R6: With the mode input high, `div_o` equals the held word.
- R7: `div_ok_o` is 1 exactly when `div_o` lies in 45 to 55 inclusive. An out-of-range word is still captured and shown on `div_o`.
- R8: A change on the mode input reaches `div_o` on the third system clock edge after it is sampled. Returning the mode to low restores 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous, at most clk/4) |
| ser_dat_i | input | 1 | Serial data, sampled on serial clock rising edges |
| ser_ld_i | input | 1 | Load strobe: high enables shifting, falling edge captures |
| margin_en_i | input | 1 | 0 selects nominal divide, 1 selects held margining word |
| div_o | output | 6 | Active feedback divide value |
| div_ok_o | output | 1 | High when div_o is within the lockable window |

## Verification
The bench sends a word whose bit-reversed value differs from it, so a port that shifts LSB first would show 52 instead of 11. It also sends an over-long burst; a design that keeps the first six bits instead of the last six would present the wrong value. It toggles the clock and data lines with the strobe low and then pulses the strobe alone. A shift register that is not gated would then capture garbage instead of the earlier word. It stops midway through a burst to catch a design that copies on the strobe level rather than its falling edge. It also tests the window edges 44, 45, 55 and 56, where an off-by-one in the range compare flips the flag, and it counts the exact cycle the mode switch appears at the output.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

    localparam int DIV_W_DEF   = 6;
    localparam int NOM_DEF     = 50;
    localparam int MIN_DEF     = 45;
    localparam int MAX_DEF     = 55;
    localparam int SYNC_DEF    = 2;

    // bit positions of the packed control sample
    localparam int CTL_W = 4;

    typedef struct packed {
        logic sclk;
        logic sdat;
        logic sld;
        logic mode;
    } ctl_sample_t;

    typedef enum logic [1:0] {
        EV_NONE    = 2'b00,
        EV_SHIFT   = 2'b01,
        EV_CAPTURE = 2'b10
    } ser_event_t;

    function automatic logic in_window(input logic [7:0] v,
                                       input int lo, input int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction

endpackage

// File: rtl/mdiv_sync.sv
module mdiv_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mdiv_shifter.sv
module mdiv_shifter
    import mdiv_pkg::*;
#(
    parameter int DIV_W   = DIV_W_DEF,
    parameter int NOM_DIV = NOM_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_s,
    input  logic             sdat_s,
    input  logic             sld_s,
    output logic [DIV_W-1:0] held_o
);

    localparam logic [DIV_W-1:0] NOM_V = DIV_W'(NOM_DIV);

    logic             sclk_d;
    logic             sld_d;
    logic [DIV_W-1:0] shreg_q;
    logic [DIV_W-1:0] held_q;
    ser_event_t       ev;

    // classify the current cycle; shifting needs the strobe high,
    // capture needs it falling, so both can never coincide
    always_comb begin
        ev = EV_NONE;
        if (sld_s && sclk_s && !sclk_d)
            ev = EV_SHIFT;
        else if (!sld_s && sld_d)
            ev = EV_CAPTURE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            sld_d   <= 1'b0;
            shreg_q <= '0;
            held_q  <= NOM_V;
        end else begin
            sclk_d <= sclk_s;
            sld_d  <= sld_s;
            case (ev)
                EV_SHIFT:   shreg_q <= {shreg_q[DIV_W-2:0], sdat_s};
                EV_CAPTURE: held_q  <= shreg_q;
                default:    ;
            endcase
        end
    end

    assign held_o = held_q;

endmodule

// File: rtl/mdiv_select.sv
module mdiv_select
    import mdiv_pkg::*;
#(
    parameter int DIV_W   = DIV_W_DEF,
    parameter int NOM_DIV = NOM_DEF,
    parameter int MIN_DIV = MIN_DEF,
    parameter int MAX_DIV = MAX_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_s,
    input  logic [DIV_W-1:0] held_i,
    output logic [DIV_W-1:0] div_o,
    output logic             ok_o
);

    localparam logic [DIV_W-1:0] NOM_V = DIV_W'(NOM_DIV);

    logic [DIV_W-1:0] pick;
    logic [DIV_W-1:0] div_q;
    logic             ok_q;

    always_comb begin
        pick = mode_s ? held_i : NOM_V;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= NOM_V;
            ok_q  <= in_window(8'(NOM_DIV), MIN_DIV, MAX_DIV);
        end else begin
            div_q <= pick;
            ok_q  <= in_window(8'(pick), MIN_DIV, MAX_DIV);
        end
    end

    assign div_o = div_q;
    assign ok_o  = ok_q;

endmodule

// File: rtl/mdiv_serial_ctrl.sv
module mdiv_serial_ctrl
    import mdiv_pkg::*;
#(
    parameter int DIV_W       = DIV_W_DEF,
    parameter int NOM_DIV     = NOM_DEF,
    parameter int MIN_DIV     = MIN_DEF,
    parameter int MAX_DIV     = MAX_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_ld_i,
    input  logic             margin_en_i,
    output logic [DIV_W-1:0] div_o,
    output logic             div_ok_o
);

    ctl_sample_t      raw;
    ctl_sample_t      syn;
    logic [DIV_W-1:0] held;

    always_comb begin
        raw.sclk = ser_clk_i;
        raw.sdat = ser_dat_i;
        raw.sld  = ser_ld_i;
        raw.mode = margin_en_i;
    end

    mdiv_sync #(
        .W      (CTL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (syn)
    );

    mdiv_shifter #(
        .DIV_W   (DIV_W),
        .NOM_DIV (NOM_DIV)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (syn.sclk),
        .sdat_s (syn.sdat),
        .sld_s  (syn.sld),
        .held_o (held)
    );

    mdiv_select #(
        .DIV_W   (DIV_W),
        .NOM_DIV (NOM_DIV),
        .MIN_DIV (MIN_DIV),
        .MAX_DIV (MAX_DIV)
    ) u_sel (
        .clk    (clk),
        .rst    (rst),
        .mode_s (syn.mode),
        .held_i (held),
        .div_o  (div_o),
        .ok_o   (div_ok_o)
    );

endmodule

// File: rtl/mdiv_serial_ctrl_chk.sv
module mdiv_serial_ctrl_chk #(
    parameter int DIV_W   = 6,
    parameter int NOM_DIV = 50,
    parameter int MIN_DIV = 45,
    parameter int MAX_DIV = 55
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_ld_i,
    input logic             margin_en_i,
    input logic [DIV_W-1:0] div_o,
    input logic             div_ok_o
);

    logic [3:0] cyc;
    logic [3:0] ld_low_cnt;
    logic [3:0] mode_same_cnt;
    logic       mode_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc           <= '0;
            ld_low_cnt    <= '0;
            mode_same_cnt <= '0;
            mode_prev     <= 1'b0;
        end else begin
            if (cyc != 4'hF) cyc <= cyc + 4'd1;
            if (ser_ld_i) ld_low_cnt <= '0;
            else if (ld_low_cnt != 4'hF) ld_low_cnt <= ld_low_cnt + 4'd1;
            mode_prev <= margin_en_i;
            if (margin_en_i != mode_prev) mode_same_cnt <= '0;
            else if (mode_same_cnt != 4'hF) mode_same_cnt <= mode_same_cnt + 4'd1;
        end
    end

    // R1
    reset_nominal_chk: assert property (@(posedge clk)
        rst |=> (div_o == DIV_W'(NOM_DIV) && div_ok_o));

    // R5
    nominal_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 4'd3 && !$past(margin_en_i, 3)) |-> (div_o == DIV_W'(NOM_DIV)));

    // R7
    window_flag_chk: assert property (@(posedge clk) disable iff (rst)
        div_ok_o == ((int'(div_o) >= MIN_DIV) && (int'(div_o) <= MAX_DIV)));

    // R4
    quiet_when_unloaded_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_low_cnt >= 4'd6 && mode_same_cnt >= 4'd5) |=> $stable(div_o));

endmodule

bind mdiv_serial_ctrl mdiv_serial_ctrl_chk #(
    .DIV_W   (DIV_W),
    .NOM_DIV (NOM_DIV),
    .MIN_DIV (MIN_DIV),
    .MAX_DIV (MAX_DIV)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ser_ld_i    (ser_ld_i),
    .margin_en_i (margin_en_i),
    .div_o       (div_o),
    .div_ok_o    (div_ok_o)
);

// File: tb/mdiv_serial_ctrl_bench.sv
`timescale 1ns/1ps
module mdiv_serial_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_ld = 1'b0;
    logic       mode = 1'b0;
    logic [5:0] div;
    logic       ok;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    mdiv_serial_ctrl u_mdiv_serial_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ser_clk_i   (ser_clk),
        .ser_dat_i   (ser_dat),
        .ser_ld_i    (ser_ld),
        .margin_en_i (mode),
        .div_o       (div),
        .div_ok_o    (ok)
    );

    // behavioural reference: inputs delayed two edges, then edge events
    logic [3:0] hist [$];
    int m_shift = 0;
    int m_hold  = 50;
    int m_div   = 50;
    bit m_ok    = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            hist = {4'h0, 4'h0, 4'h0, 4'h0};
            m_shift = 0; m_hold = 50; m_div = 50; m_ok = 1'b1;
        end else begin
            logic [3:0] s2, s3;
            hist.push_back({ser_clk, ser_dat, ser_ld, mode});
            void'(hist.pop_front());
            s2 = hist[1];
            s3 = hist[0];
            m_div = s2[0] ? m_hold : 50;
            m_ok  = (m_div >= 45) && (m_div <= 55);
            if (s2[3] && !s3[3] && s2[1])
                m_shift = ((m_shift * 2) + int'(s2[2])) % 64;
            else if (!s2[1] && s3[1])
                m_hold = m_shift;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_cmp++;
            if (int'(div) != m_div || ok != m_ok) begin
                n_bad++;
                $display("FAIL %s model: div=%0d ok=%0d expected div=%0d ok=%0d",
                         phase, div, ok, m_div, m_ok);
            end
        end
    end

    task automatic chk(input string req, input int exp_div, input bit exp_ok);
        n_cmp++;
        if (int'(div) != exp_div || ok != exp_ok) begin
            n_bad++;
            $display("FAIL %s: div=%0d ok=%0d expected div=%0d ok=%0d",
                     req, div, ok, exp_div, exp_ok);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = w[i];
            idle(3);
            ser_clk = 1'b1;
            idle(3);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send(input logic [15:0] w, input int n);
        ser_ld = 1'b1;
        idle(3);
        shift_bits(w, n);
        idle(2);
        ser_ld = 1'b0;
        idle(8);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        phase = "R1"; chk("R1", 50, 1'b1);

        phase = "R5";
        send(16'd53, 6);
        chk("R5", 50, 1'b1);

        phase = "R8";
        mode = 1'b1;
        idle(1); chk("R8", 50, 1'b1);
        idle(1); chk("R8", 50, 1'b1);
        idle(1); chk("R6", 53, 1'b1);

        phase = "R7";
        send(16'd45, 6); chk("R7", 45, 1'b1);
        send(16'd55, 6); chk("R7", 55, 1'b1);
        send(16'd44, 6); chk("R7", 44, 1'b0);
        send(16'd56, 6); chk("R7", 56, 1'b0);

        phase = "R2";
        send(16'b001011, 6); chk("R2", 11, 1'b0);

        phase = "R4";
        for (int k = 0; k < 10; k++) begin
            ser_dat = k[0];
            idle(3);
            ser_clk = ~ser_clk;
        end
        ser_clk = 1'b0;
        idle(6);
        chk("R4", 11, 1'b0);
        send(16'h0, 0);
        chk("R4", 11, 1'b0);

        phase = "R2";
        send(16'b11110011, 8); chk("R2", 51, 1'b1);

        phase = "R3";
        ser_ld = 1'b1;
        idle(3);
        shift_bits(16'b110, 3);
        idle(6); chk("R3", 51, 1'b1);
        shift_bits(16'b100, 3);
        idle(6); chk("R3", 51, 1'b1);
        ser_ld = 1'b0;
        idle(8); chk("R3", 52, 1'b1);

        phase = "R8";
        mode = 1'b0;
        idle(4); chk("R8", 50, 1'b1);

        phase = "R5";
        send(16'd47, 6);
        chk("R5", 50, 1'b1);
        mode = 1'b1;
        idle(4); chk("R5", 47, 1'b1);

        phase = "R1";
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(4); chk("R1", 50, 1'b1);
        mode = 1'b1;
        idle(4); chk("R1", 50, 1'b1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule